// File: doc/BRIEF.md
# I2C Low-Power Entry Holdoff Controller

This block sits between the system's low-power (stop) request and an I2C transfer engine. It decides when the system may be told that the I2C side is ready for clock shutdown. The block only acknowledges. Whether the module clock is then gated is left entirely to the system.

When the hold option is on and a byte (address or data) is moving on the bus, the acknowledge is deferred until the engine reports the byte boundary. When the engine is idle or disabled, the acknowledge comes on the next cycle. When the hold option is off, the acknowledge is also given on the next cycle. If a byte was moving at that point, the transfer is marked as aborted, and software must restart it with a new slave address.

A transfer that was touched by the stop request (a byte in flight when the request was accepted) raises a transfer-complete interrupt once the system wakes, provided the interrupt enable was set when the request was accepted. The aborted flag and the pending interrupt stay set until a software clear or a new START condition.

Top module: `i2c_lp_holdoff`

## Requirements
- R1: After reset, `lp_ack`, `xfer_aborted` and `tc_irq` are all 0.
- R2: With `hold_en`=1 and no byte active when the request arrives, `lp_ack` is 1 in the first cycle after the cycle in which `lp_req` is first seen high. "Byte active" means `byte_busy`=1 while both `eng_idle` and `eng_disabled` are 0.
- R3: With `hold_en`=1 and a byte active, `lp_ack` stays 0 until `byte_done` is seen high, and rises in the cycle after that.
- R4: With `hold_en`=0, `lp_ack` is 1 in the first cycle after the request, whatever the engine state. `xfer_aborted` rises together with `lp_ack` if a byte was active at the request.
- R5: Once high, `lp_ack` stays high while `lp_req` stays high, and falls in the cycle after `lp_req` is seen low.
- R6: If `lp_req` is withdrawn while the acknowledge is being deferred, no acknowledge is given, and a later `byte_done` does not produce one.
- R7: `tc_irq` rises one cycle after `lp_ack` falls, if and only if a byte was active and `irq_en` was 1 when the request was accepted.
- R8: `sw_clr` or `start_seen` clears `xfer_aborted` and `tc_irq` on the next cycle, and the clear wins over a set in the same cycle.
- R9: With `hold_en`=0 and no byte active, a request leaves `xfer_aborted` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lp_req | input | 1 | System stop-mode request, held high until wake |
| hold_en | input | 1 | Defer acknowledge to the byte boundary |
| irq_en | input | 1 | Transfer-complete interrupt enable |
| eng_idle | input | 1 | Engine reports no transfer under way |
| eng_disabled | input | 1 | Engine is disabled |
| byte_busy | input | 1 | Engine is shifting an address or data byte |
| byte_done | input | 1 | One-cycle pulse at a byte boundary |
| start_seen | input | 1 | One-cycle pulse on a new START condition |
| sw_clr | input | 1 | One-cycle software clear of flags |
| lp_ack | output | 1 | Stop-mode acknowledge |
| xfer_aborted | output | 1 | Transfer was cut short by stop entry |
| tc_irq | output | 1 | Pending transfer-complete interrupt |

## Verification
The properties assume that `lp_req` stays high from the request until the acknowledge or a deliberate withdrawal. They also assume that `byte_done` is a single-cycle pulse that only appears while a byte is active. The stimulus raises the request once per scenario and holds it until after the acknowledge has been checked. It pulses `byte_done` exactly once, at a chosen delay, and issues clears only between scenarios, except for one directed case that places a clear on the same cycle as the interrupt set.

// File: rtl/lp_hold_pkg.sv
package lp_hold_pkg;
   typedef enum logic [1:0] {
      ST_IDLE          = 2'd0,
      ST_WAIT_BYTE_END = 2'd1,
      ST_STOP_ACKED    = 2'd2,
      ST_WAKE          = 2'd3
   } lp_state_t;
endpackage

// File: rtl/lp_hold_fsm.sv
module lp_hold_fsm
   import lp_hold_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      lp_req,
   input  logic      hold_eff,
   input  logic      byte_active,
   input  logic      byte_done,
   output lp_state_t state,
   output logic      lp_ack
);
   lp_state_t nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_IDLE: begin
            if (lp_req) begin
               if (hold_eff && byte_active) nxt = ST_WAIT_BYTE_END;
               else                         nxt = ST_STOP_ACKED;
            end
         end
         ST_WAIT_BYTE_END: begin
            if (!lp_req)                         nxt = ST_IDLE;
            else if (byte_done || !byte_active)  nxt = ST_STOP_ACKED;
         end
         ST_STOP_ACKED: begin
            if (!lp_req) nxt = ST_WAKE;
         end
         ST_WAKE: nxt = ST_IDLE;
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
   end

   assign lp_ack = (state == ST_STOP_ACKED);
endmodule

// File: rtl/lp_hold_flags.sv
module lp_hold_flags
   import lp_hold_pkg::*;
#(
   parameter bit CLEAR_WINS = 1'b1
)(
   input  logic      clk,
   input  logic      rst_n,
   input  lp_state_t state,
   input  logic      lp_req,
   input  logic      hold_eff,
   input  logic      irq_en,
   input  logic      byte_active,
   input  logic      clr,
   output logic      xfer_aborted,
   output logic      tc_irq
);
   logic accept, ev_abort, ev_wake;
   logic irq_snap, touched;
   logic abort_nxt, irq_nxt;
   logic irq_set;

   assign accept   = (state == ST_IDLE) && lp_req;
   assign ev_abort = accept && !hold_eff && byte_active;
   assign ev_wake  = (state == ST_WAKE);
   assign irq_set  = ev_wake && touched && irq_snap;

   generate
      if (CLEAR_WINS) begin : g_clr_first
         always_comb begin
            abort_nxt = clr ? 1'b0 : (xfer_aborted | ev_abort);
            irq_nxt   = clr ? 1'b0 : (tc_irq | irq_set);
         end
      end else begin : g_set_first
         always_comb begin
            abort_nxt = ev_abort ? 1'b1 : (xfer_aborted & ~clr);
            irq_nxt   = irq_set  ? 1'b1 : (tc_irq & ~clr);
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_snap     <= 1'b0;
         touched      <= 1'b0;
         xfer_aborted <= 1'b0;
         tc_irq       <= 1'b0;
      end else begin
         if (accept) begin
            irq_snap <= irq_en;
            touched  <= byte_active;
         end else if (ev_wake) begin
            touched  <= 1'b0;
         end
         xfer_aborted <= abort_nxt;
         tc_irq       <= irq_nxt;
      end
   end
endmodule

// File: rtl/i2c_lp_holdoff.sv
module i2c_lp_holdoff
   import lp_hold_pkg::*;
#(
   parameter bit HOLD_SUPPORTED = 1'b1,
   parameter bit CLEAR_WINS     = 1'b1
)(
   input  logic clk,
   input  logic rst_n,
   input  logic lp_req,
   input  logic hold_en,
   input  logic irq_en,
   input  logic eng_idle,
   input  logic eng_disabled,
   input  logic byte_busy,
   input  logic byte_done,
   input  logic start_seen,
   input  logic sw_clr,
   output logic lp_ack,
   output logic xfer_aborted,
   output logic tc_irq
);
   lp_state_t state;
   logic      hold_eff;
   logic      byte_active;
   logic      clr;

   generate
      if (HOLD_SUPPORTED) begin : g_hold
         assign hold_eff = hold_en;
      end else begin : g_nohold
         assign hold_eff = 1'b0;
      end
   endgenerate

   assign byte_active = byte_busy && !eng_idle && !eng_disabled;
   assign clr         = sw_clr || start_seen;

   lp_hold_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .lp_req      (lp_req),
      .hold_eff    (hold_eff),
      .byte_active (byte_active),
      .byte_done   (byte_done),
      .state       (state),
      .lp_ack      (lp_ack)
   );

   lp_hold_flags #(.CLEAR_WINS(CLEAR_WINS)) u_flags (
      .clk          (clk),
      .rst_n        (rst_n),
      .state        (state),
      .lp_req       (lp_req),
      .hold_eff     (hold_eff),
      .irq_en       (irq_en),
      .byte_active  (byte_active),
      .clr          (clr),
      .xfer_aborted (xfer_aborted),
      .tc_irq       (tc_irq)
   );
endmodule

// File: rtl/lp_hold_chk.sv
module lp_hold_chk
   import lp_hold_pkg::*;
(
   input logic      clk,
   input logic      rst_n,
   input logic      lp_req,
   input logic      hold_en,
   input logic      eng_idle,
   input logic      eng_disabled,
   input logic      byte_busy,
   input logic      start_seen,
   input logic      sw_clr,
   input logic      lp_ack,
   input logic      xfer_aborted,
   input logic      tc_irq,
   input lp_state_t state
);
   logic act;
   assign act = byte_busy && !eng_idle && !eng_disabled;

   AST_ACK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      lp_ack && lp_req |=> lp_ack); // R5
   AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      lp_ack && !lp_req |=> !lp_ack); // R5
   AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lp_ack) |-> $past(lp_req)); // R2
   AST_HOLD_DEFERS: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_IDLE && lp_req && hold_en && act |=> !lp_ack); // R3
   AST_NOHOLD_FAST: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_IDLE && lp_req && !hold_en |=> lp_ack); // R4
   AST_WITHDRAW: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_WAIT_BYTE_END && !lp_req |=> !lp_ack); // R6
   AST_IRQ_AFTER_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tc_irq) |-> $past(state == ST_WAKE)); // R7
   AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      sw_clr || start_seen |=> !xfer_aborted && !tc_irq); // R8
   AST_NO_FALSE_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_IDLE && lp_req && !act && !sw_clr && !start_seen
      |=> $stable(xfer_aborted)); // R9
endmodule

bind i2c_lp_holdoff lp_hold_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .lp_req       (lp_req),
   .hold_en      (hold_en),
   .eng_idle     (eng_idle),
   .eng_disabled (eng_disabled),
   .byte_busy    (byte_busy),
   .start_seen   (start_seen),
   .sw_clr       (sw_clr),
   .lp_ack       (lp_ack),
   .xfer_aborted (xfer_aborted),
   .tc_irq       (tc_irq),
   .state        (state)
);

// File: tb/sim_i2c_lp_holdoff.sv
module sim_i2c_lp_holdoff;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic lp_req = 0, hold_en = 0, irq_en = 0, eng_idle = 0, eng_disabled = 0;
   logic byte_busy = 0, byte_done = 0, start_seen = 0, sw_clr = 0;
   logic lp_ack, xfer_aborted, tc_irq;

   int n_run = 0, n_fail = 0;
   bit finished = 0;

   always #10 clk = ~clk; // 50 MHz

   i2c_lp_holdoff u0 (.*);

   typedef struct packed {
      logic       hold;
      logic       irq;
      logic       busy;
      logic       idle;
      logic       dis;
      logic [3:0] waitn;
      logic [3:0] delay;
      logic       abort;
      logic       tcirq;
   } vec_t;

   localparam vec_t TBL [8] = '{
      '{1'b1,1'b1,1'b1,1'b0,1'b0,4'd3,4'd4,1'b0,1'b1}, // R3 deferred, irq
      '{1'b1,1'b0,1'b1,1'b0,1'b0,4'd1,4'd2,1'b0,1'b0}, // R3 no irq enable
      '{1'b1,1'b1,1'b0,1'b1,1'b0,4'd0,4'd1,1'b0,1'b0}, // R2 engine idle
      '{1'b1,1'b1,1'b1,1'b0,1'b1,4'd0,4'd1,1'b0,1'b0}, // R2 engine disabled
      '{1'b0,1'b1,1'b1,1'b0,1'b0,4'd0,4'd1,1'b1,1'b1}, // R4 abort, irq
      '{1'b0,1'b0,1'b1,1'b0,1'b0,4'd0,4'd1,1'b1,1'b0}, // R4 abort, no irq
      '{1'b0,1'b1,1'b0,1'b1,1'b0,4'd0,4'd1,1'b0,1'b0}, // R9 no byte
      '{1'b1,1'b1,1'b1,1'b0,1'b0,4'd6,4'd7,1'b0,1'b1}  // R3 long byte
   };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic clear_flags(input bit use_start);
      @(negedge clk);
      if (use_start) start_seen = 1; else sw_clr = 1;
      @(negedge clk);
      start_seen = 0; sw_clr = 0;
   endtask

   initial begin
      #(20 * 20000);
      if (!finished) begin
         n_run++; n_fail++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      int got;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(lp_ack == 0 && xfer_aborted == 0 && tc_irq == 0, "R1 reset",
          {lp_ack, xfer_aborted, tc_irq}, 0);
      rst_n = 1;
      @(negedge clk);

      foreach (TBL[k]) begin
         vec_t v = TBL[k];
         hold_en = v.hold; irq_en = v.irq; byte_busy = v.busy;
         eng_idle = v.idle; eng_disabled = v.dis;
         lp_req = 1; byte_done = 0;
         got = 0;
         for (int i = 1; i <= 15; i++) begin
            @(negedge clk);
            if (lp_ack && got == 0) got = i;
            byte_done = (i == int'(v.waitn)) && v.busy;
         end
         byte_done = 0;
         chk(got == int'(v.delay), v.hold ? "R2/R3 ack delay" : "R4 ack delay",
             got, v.delay);
         chk(xfer_aborted == v.abort, v.abort ? "R4 aborted" : "R9 aborted",
             xfer_aborted, v.abort);
         chk(lp_ack == 1, "R5 ack held", lp_ack, 1);
         lp_req = 0; byte_busy = 0;
         @(negedge clk);
         chk(lp_ack == 0, "R5 ack drop", lp_ack, 0);
         @(negedge clk);
         chk(tc_irq == v.tcirq, "R7 irq after wake", tc_irq, v.tcirq);
         clear_flags(k[0]);
         chk(xfer_aborted == 0 && tc_irq == 0, "R8 clear",
             {xfer_aborted, tc_irq}, 0);
      end

      // R6 withdraw while deferred
      hold_en = 1; irq_en = 1; byte_busy = 1; eng_idle = 0; eng_disabled = 0;
      lp_req = 1;
      got = 0;
      repeat (3) begin @(negedge clk); got |= lp_ack; end
      lp_req = 0;
      repeat (2) begin @(negedge clk); got |= lp_ack; end
      byte_done = 1;
      @(negedge clk); got |= lp_ack; byte_done = 0;
      repeat (3) begin @(negedge clk); got |= lp_ack; end
      chk(got == 0, "R6 no ack after withdraw", got, 0);
      chk(tc_irq == 0 && xfer_aborted == 0, "R6 flags quiet",
          {tc_irq, xfer_aborted}, 0);

      // R8 clear in the same cycle as the interrupt set
      hold_en = 0; irq_en = 1; byte_busy = 1;
      lp_req = 1;
      repeat (3) @(negedge clk);
      lp_req = 0;
      @(negedge clk);   // now in wake; set happens at next edge
      sw_clr = 1;
      @(negedge clk);
      sw_clr = 0;
      chk(tc_irq == 0, "R8 clear wins", tc_irq, 0);
      chk(xfer_aborted == 0, "R8 clear aborted", xfer_aborted, 0);
      byte_busy = 0;
      repeat (2) @(negedge clk);

      // R8 start condition clears an abort
      hold_en = 0; irq_en = 0; byte_busy = 1;
      lp_req = 1;
      repeat (2) @(negedge clk);
      chk(xfer_aborted == 1, "R4 aborted set", xfer_aborted, 1);
      lp_req = 0; byte_busy = 0;
      repeat (2) @(negedge clk);
      start_seen = 1;
      @(negedge clk);
      start_seen = 0;
      chk(xfer_aborted == 0, "R8 start clears", xfer_aborted, 0);

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule